// File: doc/BRIEF.md
# Thresholded Event Counter

A performance-monitor counter that takes one event multiplicity per clock: how many times an event happened in that cycle, such as the number of stalled issue slots. It does not simply add that number. It first compares the number against a programmed threshold using a chosen relation. On cycles where the relation holds, it adds either the multiplicity itself or a single unit, as configured. A threshold of zero turns the comparison off, and the block then behaves as a plain summing counter.

Configuration is written through a one-cycle write strobe that carries every field together. The block reports the largest threshold it supports on a constant capability output. A write whose threshold exceeds that limit is refused: an error pulse follows, and the earlier settings stay in force. The counter runs either at full width or at a narrow width. It wraps modulo the active width, and each wrap sets a sticky overflow flag.

The event input is a valid/ready stream with no back-pressure. `ev_ready` is held high, so a beat is consumed on every rising edge where `ev_valid` is high. A low `ev_valid` means no event data for that cycle.

Top module: `thr_evt_counter`

## Requirements
- R1: A synchronous reset clears the count, the overflow flag and the error flag. It also sets the threshold to 0, the compare code to 0, count-by-one off and the narrow width.
- R2: When the stored threshold is 0, every accepted beat adds its full `ev_data` value to the count, whatever the compare code and count-by-one settings are.
- R3: When the threshold is nonzero, a beat passes when `ev_data` stands in the selected relation to the threshold. The codes are 0 for not-equal, 1 for equal, 2 for greater-or-equal and 3 for less-than. The count changes only on passing beats.
- R4: A passing beat adds `ev_data` when `cfg_unit` is 0 and adds exactly 1 when `cfg_unit` is 1.
- R5: `thr_cap` always shows the largest accepted threshold, which is THR_MAX and 255 by default. A write whose 12-bit threshold is above `thr_cap` is refused: `cfg_err` is high for exactly the next cycle and all stored settings stay unchanged. Any other write sets `cfg_err` low in the next cycle.
- R6: With HAS_THR = 0, `thr_cap` reads 0 and every write with a nonzero threshold is refused, as in R5.
- R7: `cfg_wide` = 1 selects the full CNT_W-bit counter and 0 selects NARROW_W bits. In narrow mode the count wraps modulo 2^NARROW_W and the bits above NARROW_W read 0. Switching to narrow mode discards those upper bits.
- R8: An addition that carries out of the active width sets `ovf_q`. The flag stays set until `ovf_clr` is applied. When a carry and `ovf_clr` fall in the same cycle, the carry wins.
- R9: A cycle with `ev_valid` low leaves the count unchanged, and `ev_ready` is always high.
- R10: An accepted write takes effect from the next cycle. A beat in the same cycle as the write is judged under the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | Event beat present this cycle |
| ev_ready | output | 1 | Always high; the block never stalls |
| ev_data | input | EV_W | Event multiplicity for this cycle |
| cfg_wr | input | 1 | Write strobe for all configuration fields |
| cfg_thr | input | 12 | Threshold, 0 turns comparison off |
| cfg_cmp | input | 2 | Relation code (R3) |
| cfg_unit | input | 1 | 1: add one per passing beat |
| cfg_wide | input | 1 | 1: full width, 0: narrow width |
| cfg_err | output | 1 | Pulse one cycle after a refused write |
| thr_cap | output | 12 | Largest accepted threshold |
| ovf_clr | input | 1 | Clears the overflow flag |
| count_q | output | CNT_W | Counter value |
| ovf_q | output | 1 | Sticky overflow flag |

## Verification
The assertions take for granted that every input is known (never X or Z) at each rising edge. They also assume reset is held for at least one edge before the first event, and that CNT_W is larger than NARROW_W. The stimulus drives every input to a defined value on the falling edge, starts with several reset cycles, and uses a reduced-width instance so that wraps happen within a short run. Refused writes are aimed both just above the capability and at the top of the 12-bit field.

// File: rtl/thr_evt_pkg.sv
package thr_evt_pkg;
  localparam int unsigned THR_FIELD_W = 12;

  typedef enum logic [1:0] {
    REL_NE = 2'd0,
    REL_EQ = 2'd1,
    REL_GE = 2'd2,
    REL_LT = 2'd3
  } rel_e;

  typedef struct packed {
    logic [THR_FIELD_W-1:0] thr;
    rel_e                   rel;
    logic                   unit;
    logic                   wide;
  } thr_cfg_t;
endpackage

// File: rtl/thr_evt_cfg.sv
module thr_evt_cfg
  import thr_evt_pkg::*;
#(
  parameter int unsigned THR_MAX = 255,
  parameter bit          HAS_THR = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  thr_cfg_t               cfg_in,
  output thr_cfg_t               cfg_q,
  output logic                   err_q,
  output logic [THR_FIELD_W-1:0] cap
);
  localparam logic [THR_FIELD_W-1:0] CAP_VAL =
    HAS_THR ? THR_FIELD_W'(THR_MAX) : '0;

  logic refuse;

  assign cap    = CAP_VAL;
  assign refuse = wr && (cfg_in.thr > CAP_VAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '{thr: '0, rel: REL_NE, unit: 1'b0, wide: 1'b0};
      err_q <= 1'b0;
    end else begin
      err_q <= refuse;
      if (wr && !refuse) cfg_q <= cfg_in;
    end
  end
endmodule

// File: rtl/thr_evt_gate.sv
module thr_evt_gate
  import thr_evt_pkg::*;
#(
  parameter int unsigned EV_W = 8
) (
  input  thr_cfg_t        cfg,
  input  logic            ev_valid,
  input  logic [EV_W-1:0] ev_data,
  output logic [EV_W-1:0] inc
);
  logic [THR_FIELD_W-1:0] ev_ext;
  logic                   pass;

  assign ev_ext = THR_FIELD_W'(ev_data);

  always_comb begin
    unique case (cfg.rel)
      REL_NE:  pass = (ev_ext != cfg.thr);
      REL_EQ:  pass = (ev_ext == cfg.thr);
      REL_GE:  pass = (ev_ext >= cfg.thr);
      default: pass = (ev_ext <  cfg.thr);
    endcase
  end

  always_comb begin
    inc = '0;
    if (ev_valid) begin
      if (cfg.thr == '0)  inc = ev_data;
      else if (pass)      inc = cfg.unit ? EV_W'(1) : ev_data;
    end
  end
endmodule

// File: rtl/thr_evt_acc.sv
module thr_evt_acc #(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned EV_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide,
  input  logic [EV_W-1:0]  inc,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam int unsigned UPPER_W = CNT_W - NARROW_W;

  logic [CNT_W:0]    sum_w;
  logic [NARROW_W:0] sum_n;
  logic [CNT_W-1:0]  nxt;
  logic              carry;

  assign sum_w = {1'b0, cnt} + (CNT_W+1)'(inc);
  assign sum_n = {1'b0, cnt[NARROW_W-1:0]} + (NARROW_W+1)'(inc);

  always_comb begin
    if (wide) begin
      nxt   = sum_w[CNT_W-1:0];
      carry = sum_w[CNT_W];
    end else begin
      nxt   = {{UPPER_W{1'b0}}, sum_n[NARROW_W-1:0]};
      carry = sum_n[NARROW_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      cnt <= nxt;
      if (carry)        ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/thr_evt_counter.sv
module thr_evt_counter
  import thr_evt_pkg::*;
#(
  parameter int unsigned EV_W     = 8,
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned THR_MAX  = 255,
  parameter bit          HAS_THR  = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ev_valid,
  output logic                   ev_ready,
  input  logic [EV_W-1:0]        ev_data,
  input  logic                   cfg_wr,
  input  logic [THR_FIELD_W-1:0] cfg_thr,
  input  logic [1:0]             cfg_cmp,
  input  logic                   cfg_unit,
  input  logic                   cfg_wide,
  output logic                   cfg_err,
  output logic [THR_FIELD_W-1:0] thr_cap,
  input  logic                   ovf_clr,
  output logic [CNT_W-1:0]       count_q,
  output logic                   ovf_q
);
  localparam int unsigned UPPER_W = CNT_W - NARROW_W;

  thr_cfg_t        cfg_in, cfg_q;
  logic [EV_W-1:0] inc;
  logic [CNT_W-1:0] acc_cnt;

  assign ev_ready = 1'b1;
  assign cfg_in   = '{thr: cfg_thr, rel: rel_e'(cfg_cmp), unit: cfg_unit, wide: cfg_wide};

  thr_evt_cfg #(.THR_MAX(THR_MAX), .HAS_THR(HAS_THR)) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .cfg_in(cfg_in),
    .cfg_q(cfg_q), .err_q(cfg_err), .cap(thr_cap)
  );

  thr_evt_gate #(.EV_W(EV_W)) u_gate (
    .cfg(cfg_q), .ev_valid(ev_valid), .ev_data(ev_data), .inc(inc)
  );

  thr_evt_acc #(.CNT_W(CNT_W), .NARROW_W(NARROW_W), .EV_W(EV_W)) u_acc (
    .clk(clk), .rst(rst), .wide(cfg_q.wide), .inc(inc),
    .ovf_clr(ovf_clr), .cnt(acc_cnt), .ovf(ovf_q)
  );

  assign count_q = cfg_q.wide ? acc_cnt : {{UPPER_W{1'b0}}, acc_cnt[NARROW_W-1:0]};
endmodule

// File: rtl/thr_evt_chk.sv
module thr_evt_chk #(
  parameter int unsigned EV_W     = 8,
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned NARROW_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_valid,
  input logic [EV_W-1:0]  ev_data,
  input logic             cfg_wr,
  input logic [11:0]      cfg_thr,
  input logic [11:0]      thr_cap,
  input logic             cfg_err,
  input logic             ovf_clr,
  input logic             ovf_q,
  input logic [CNT_W-1:0] count_q,
  input logic [11:0]      thr_q,
  input logic             unit_q,
  input logic             wide_q,
  input logic [CNT_W-1:0] acc_cnt
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (count_q == '0) && !ovf_q && !cfg_err);

  assert_raw_add_R2: assert property (@(posedge clk) disable iff (rst)
    ev_valid && (thr_q == '0) && wide_q && !cfg_wr
    |=> count_q == $past(count_q) + CNT_W'($past(ev_data)));

  assert_unit_step_R4: assert property (@(posedge clk) disable iff (rst)
    ev_valid && (thr_q != '0) && unit_q && wide_q && !cfg_wr
    |=> CNT_W'(count_q - $past(count_q)) <= CNT_W'(1));

  assert_refuse_keep_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && (cfg_thr > thr_cap)
    |=> cfg_err && $stable(thr_q) && $stable(unit_q) && $stable(wide_q));

  assert_narrow_upper_R7: assert property (@(posedge clk) disable iff (rst)
    !wide_q && !cfg_wr |=> acc_cnt[CNT_W-1:NARROW_W] == '0);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovf_q && !ovf_clr |=> ovf_q);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !ev_valid && !cfg_wr |=> $stable(count_q));
endmodule

bind thr_evt_counter thr_evt_chk #(.EV_W(EV_W), .CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_data(ev_data),
  .cfg_wr(cfg_wr), .cfg_thr(cfg_thr), .thr_cap(thr_cap), .cfg_err(cfg_err),
  .ovf_clr(ovf_clr), .ovf_q(ovf_q), .count_q(count_q),
  .thr_q(cfg_q.thr), .unit_q(cfg_q.unit), .wide_q(cfg_q.wide), .acc_cnt(acc_cnt)
);

// File: tb/tb_thr_evt_counter.sv
module tb_thr_evt_counter;
  localparam int CW = 16;
  localparam int NW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, ev_valid = 1'b0, cfg_wr = 1'b0, cfg_unit = 1'b0, cfg_wide = 1'b0, ovf_clr = 1'b0;
  logic [7:0]  ev_data = '0;
  logic [11:0] cfg_thr = '0;
  logic [1:0]  cfg_cmp = '0;
  logic        ev_ready, cfg_err, ovf_q, nt_ready, nt_err, nt_ovf;
  logic [11:0] thr_cap, nt_cap;
  logic [CW-1:0] count_q, nt_count;

  thr_evt_counter #(.CNT_W(CW), .NARROW_W(NW)) dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_data(ev_data),
    .cfg_wr(cfg_wr), .cfg_thr(cfg_thr), .cfg_cmp(cfg_cmp), .cfg_unit(cfg_unit),
    .cfg_wide(cfg_wide), .cfg_err(cfg_err), .thr_cap(thr_cap), .ovf_clr(ovf_clr),
    .count_q(count_q), .ovf_q(ovf_q));

  thr_evt_counter #(.CNT_W(CW), .NARROW_W(NW), .HAS_THR(1'b0)) dut_nt (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(nt_ready), .ev_data(ev_data),
    .cfg_wr(cfg_wr), .cfg_thr(cfg_thr), .cfg_cmp(cfg_cmp), .cfg_unit(cfg_unit),
    .cfg_wide(cfg_wide), .cfg_err(nt_err), .thr_cap(nt_cap), .ovf_clr(ovf_clr),
    .count_q(nt_count), .ovf_q(nt_ovf));

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_thr, m_cmp;
  bit m_unit, m_wide, m_ovf, m_err, m_nt_err;
  logic [CW-1:0] m_cnt;

  always @(posedge clk) begin : model
    int inc;
    bit pass, carry;
    logic [CW:0] sw;
    logic [NW:0] sn;
    if (rst) begin
      m_thr = 0; m_cmp = 0; m_unit = 0; m_wide = 0;
      m_cnt = '0; m_ovf = 0; m_err = 0; m_nt_err = 0;
    end else begin
      inc = 0;
      if (ev_valid) begin
        case (m_cmp)
          0: pass = (int'(ev_data) != m_thr);
          1: pass = (int'(ev_data) == m_thr);
          2: pass = (int'(ev_data) >= m_thr);
          default: pass = (int'(ev_data) < m_thr);
        endcase
        if (m_thr == 0) inc = int'(ev_data);
        else if (pass)  inc = m_unit ? 1 : int'(ev_data);
      end
      if (m_wide) begin
        sw = {1'b0, m_cnt} + (CW+1)'(inc);
        carry = sw[CW]; m_cnt = sw[CW-1:0];
      end else begin
        sn = {1'b0, m_cnt[NW-1:0]} + (NW+1)'(inc);
        carry = sn[NW]; m_cnt = CW'(sn[NW-1:0]);
      end
      if (carry) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      m_err = cfg_wr && (int'(cfg_thr) > 255);
      m_nt_err = cfg_wr && (cfg_thr != 0);
      if (cfg_wr && !m_err) begin
        m_thr = int'(cfg_thr); m_cmp = int'(cfg_cmp); m_unit = cfg_unit; m_wide = cfg_wide;
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic [CW-1:0] exp_cnt;
    if (!done) begin
      exp_cnt = m_wide ? m_cnt : CW'(m_cnt[NW-1:0]);
      chk(cur_req, 64'(count_q), 64'(exp_cnt), "count");
      chk(cur_req, 64'(ovf_q), 64'(m_ovf), "overflow");
      chk(cur_req, 64'(cfg_err), 64'(m_err), "cfg_err");
      chk(rst ? "R1" : "R6", 64'(nt_err), 64'(rst ? 1'b0 : m_nt_err), "no-threshold cfg_err");
    end
  end

  task automatic beat(bit v, int e, bit clr = 1'b0);
    @(negedge clk);
    ev_valid = v; ev_data = 8'(e); cfg_wr = 1'b0; ovf_clr = clr;
  endtask

  task automatic wcfg(int thr, int cmp, bit unit, bit wide, bit v = 1'b0, int e = 0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_thr = 12'(thr); cfg_cmp = 2'(cmp); cfg_unit = unit; cfg_wide = wide;
    ev_valid = v; ev_data = 8'(e); ovf_clr = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", 64'(count_q), 0, "reset count");
    chk("R1", 64'(ovf_q), 0, "reset overflow");
    chk("R5", 64'(thr_cap), 255, "capability");
    chk("R6", 64'(nt_cap), 0, "no-threshold capability");
    chk("R9", 64'(ev_ready), 1, "ready");
    rst = 1'b0;
    // R2: threshold 0 ignores compare and unit settings
    cur_req = "R2";
    wcfg(0, 3, 1'b1, 1'b1);
    beat(1, 5); beat(1, 0); beat(1, 200); beat(1, 1);
    // R3 and R4: every relation, both count modes
    for (int u = 0; u < 2; u++)
      for (int c = 0; c < 4; c++) begin
        cur_req = (u == 0) ? "R3" : "R4";
        wcfg(10, c, u[0], 1'b1);
        beat(1, 9); beat(1, 10); beat(1, 11); beat(1, 0); beat(1, 255);
      end
    // R9: no valid, no change
    cur_req = "R9";
    beat(0, 100); beat(0, 7);
    // R10: beat alongside a write uses the old settings
    cur_req = "R10";
    wcfg(0, 0, 1'b0, 1'b1);
    wcfg(10, 1, 1'b1, 1'b1, 1'b1, 50);
    beat(1, 50); beat(1, 10);
    // R5: refused writes keep the settings
    cur_req = "R5";
    wcfg(256, 0, 1'b0, 1'b0); beat(1, 10); beat(1, 3);
    wcfg(4095, 2, 1'b0, 1'b0); beat(1, 10);
    wcfg(255, 2, 1'b0, 1'b1); beat(1, 255); beat(1, 254);
    // R8: wide wrap, sticky flag and clear
    cur_req = "R8";
    wcfg(0, 0, 1'b0, 1'b1);
    for (int i = 0; i < 260; i++) beat(1, 255);
    beat(0, 0); beat(0, 0, 1'b1); beat(1, 3);
    // R7: narrow width discards upper bits and wraps at 2^NW
    cur_req = "R7";
    wcfg(0, 0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) beat(1, 100);
    beat(1, 0, 1'b1); beat(1, 200);
    // Mixed stimulus covering all settings, refused writes and clears
    cur_req = "R8";
    for (int i = 0; i < 2500; i++) begin
      if ($urandom_range(0, 15) == 0)
        wcfg($urandom_range(0, 300), $urandom_range(0, 3), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), $urandom_range(0, 255));
      else
        beat(1'($urandom_range(0, 3) != 0), $urandom_range(0, 255), $urandom_range(0, 7) == 0);
    end
    beat(0, 0);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule